// File: doc/BRIEF.md
# Peripheral Idle Handshake Controller

This block stands between a peripheral and the system power manager and decides how the peripheral answers a low-power request. A two-bit policy field selects one of three behaviours. In the first, the request is granted at once. In the second, it is never granted. In the third, it is granted only once the peripheral has no interrupt line raised and no internal event outstanding.

After the grant, a second two-bit field chooses which of the two clocks must keep running: the interface clock, the functional clock, both or neither. The block reports this choice through two keep-alive hints. Outside the idle state both hints ask for their clocks.

While the peripheral is idle, a newly raised interrupt or event produces a wake-up request toward the power manager. The wake-up request, the grant and the keep-alive hints all return to their active values one cycle after the power manager withdraws its request.

Top module: `idle_handshake_ctrl`

## Requirements
- R1: With the policy field at 00, an idle request is acknowledged (idle_ack high) at the first clock edge that samples idle_req high, whatever the pending inputs show.
- R2: With the policy field at 01, idle_ack is never raised.
- R3: The reserved policy value 11 behaves as 01: idle_ack is never raised.
- R4: With the policy field at 10, idle_ack rises at the first clock edge that samples idle_req high while every bit of irq_pend and evt_pend is 0. The condition is evaluated again at each edge while the grant is withheld.
- R5: Once raised, idle_ack stays high as long as idle_req stays high, even if the policy field or the pending inputs change.
- R6: At the first clock edge that samples idle_req low, idle_ack falls.
- R7: While idle_ack is high, keep_iclk equals bit 0 of clk_act and keep_fclk equals bit 1 of clk_act, as sampled at the same edge. So 00 keeps neither clock, 01 keeps only the interface clock, 10 keeps only the functional clock and 11 keeps both. While idle_ack is low, both outputs are 1.
- R8: wake_req goes high at an edge where the acknowledge was already held and idle_req is high, if any bit of irq_pend or evt_pend is 1 at that edge after being 0 at the edge before. It then stays high until the edge that samples idle_req low, and it is 0 whenever idle_ack was 0 at the previous edge.
- R9: During and just after reset, idle_ack and wake_req are 0 and both keep outputs are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idle_mode | input | 2 | Idle policy: 00 immediate, 01 never, 10 conditional, 11 reserved (never) |
| clk_act | input | 2 | Clocks kept in idle: bit 0 interface, bit 1 functional |
| idle_req | input | 1 | Low-power request from the power manager |
| irq_pend | input | NUM_IRQ | Raised interrupt lines of the peripheral |
| evt_pend | input | NUM_EVT | Outstanding internal events of the peripheral |
| idle_ack | output | 1 | Idle granted; clocks may be gated |
| keep_iclk | output | 1 | Interface clock must keep running |
| keep_fclk | output | 1 | Functional clock must keep running |
| wake_req | output | 1 | Wake-up request to the power manager |

## Verification
The bench builds the block with three interrupt lines and two event lines. This keeps the pending vectors small enough that random stimulus often clears every line, which lets the conditional policy grant the request. The same small vectors often produce a rise on a single line while the grant is held, which exercises the wake-up path. With five pending bits in total, a rise on the top interrupt bit and a rise on the top event bit are both reached, so the width of each pending vector gets tested.

// File: rtl/idle_hs_pkg.sv
package idle_hs_pkg;

    typedef enum logic [1:0] {
        IM_FORCE = 2'b00,
        IM_NEVER = 2'b01,
        IM_SMART = 2'b10,
        IM_RSVD  = 2'b11
    } idle_mode_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_IDLE = 1'b1
    } idle_state_e;

    typedef struct packed {
        idle_state_e st;
        logic        wake;
        logic        keep_if;
        logic        keep_fn;
    } hs_regs_t;

    localparam hs_regs_t HS_RESET = '{st: ST_RUN, wake: 1'b0, keep_if: 1'b1, keep_fn: 1'b1};

endpackage

// File: rtl/idle_pend_mon.sv
module idle_pend_mon #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pend_i,
    output logic             any_o,
    output logic             rise_o
);
    logic [WIDTH-1:0] prev_d, prev_q;
    logic [WIDTH-1:0] edge_bits;

    always_comb begin
        prev_d    = pend_i;
        edge_bits = pend_i & ~prev_q;
        any_o     = |pend_i;
        rise_o    = |edge_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    // R8
    rise_has_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> any_o);

endmodule

// File: rtl/idle_grant_policy.sv
module idle_grant_policy
    import idle_hs_pkg::*;
(
    input  idle_mode_e mode_i,
    input  logic       busy_i,
    output logic       grant_o
);
    always_comb begin
        unique case (mode_i)
            IM_FORCE: grant_o = 1'b1;
            IM_SMART: grant_o = !busy_i;
            IM_NEVER: grant_o = 1'b0;
            default:  grant_o = 1'b0;
        endcase
    end

    // R3
    always_comb begin
        rsvd_no_grant_chk: assert (!(mode_i == IM_RSVD && grant_o === 1'b1));
    end

endmodule

// File: rtl/idle_handshake_ctrl.sv
module idle_handshake_ctrl
    import idle_hs_pkg::*;
#(
    parameter int NUM_IRQ = 4,
    parameter int NUM_EVT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         idle_mode,
    input  logic [1:0]         clk_act,
    input  logic               idle_req,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic [NUM_EVT-1:0] evt_pend,
    output logic               idle_ack,
    output logic               keep_iclk,
    output logic               keep_fclk,
    output logic               wake_req
);
    localparam int PEND_W = NUM_IRQ + NUM_EVT;

    logic [PEND_W-1:0] pend_all;
    logic              busy, fresh, grant;
    idle_mode_e        mode;
    hs_regs_t          r_d, r_q;

    assign pend_all = {evt_pend, irq_pend};
    assign mode     = idle_mode_e'(idle_mode);

    idle_pend_mon #(.WIDTH(PEND_W)) u_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend_all),
        .any_o  (busy),
        .rise_o (fresh)
    );

    idle_grant_policy u_policy (
        .mode_i  (mode),
        .busy_i  (busy),
        .grant_o (grant)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_RUN: begin
                r_d.wake = 1'b0;
                if (idle_req && grant) r_d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (!idle_req) begin
                    r_d.st   = ST_RUN;
                    r_d.wake = 1'b0;
                end else begin
                    r_d.wake = r_q.wake | fresh;
                end
            end
            default: r_d = HS_RESET;
        endcase
        if (r_d.st == ST_IDLE) begin
            r_d.keep_if = clk_act[0];
            r_d.keep_fn = clk_act[1];
        end else begin
            r_d.keep_if = 1'b1;
            r_d.keep_fn = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= HS_RESET;
        else        r_q <= r_d;
    end

    assign idle_ack  = (r_q.st == ST_IDLE);
    assign wake_req  = r_q.wake;
    assign keep_iclk = r_q.keep_if;
    assign keep_fclk = r_q.keep_fn;

    // R1
    force_grants_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_mode == 2'b00 && idle_req) |=> idle_ack);

    // R2
    never_grants_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_ack && idle_mode == 2'b01) |=> !idle_ack);

    // R4
    smart_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_ack && idle_mode == 2'b10 && ((|irq_pend) || (|evt_pend))) |=> !idle_ack);

    // R5
    ack_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_ack && idle_req) |=> idle_ack);

    // R6
    ack_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_req |=> (!idle_ack && !wake_req));

    // R7
    awake_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_ack |-> (keep_iclk && keep_fclk));

    // R8
    wake_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_ack |=> !wake_req);

endmodule

// File: tb/idle_handshake_ctrl_test.sv
module idle_handshake_ctrl_test;
    localparam int NI = 3;
    localparam int NE = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    idle_mode = 2'b01;
    logic [1:0]    clk_act = 2'b00;
    logic          idle_req = 1'b0;
    logic [NI-1:0] irq_pend = '0;
    logic [NE-1:0] evt_pend = '0;
    logic          idle_ack, keep_iclk, keep_fclk, wake_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic m_ack, m_wake, m_ki, m_kf;
    logic [NI-1:0] m_pi;
    logic [NE-1:0] m_pe;

    always #2.5 clk = ~clk;

    idle_handshake_ctrl #(.NUM_IRQ(NI), .NUM_EVT(NE)) uut (
        .clk(clk), .rst_n(rst_n), .idle_mode(idle_mode), .clk_act(clk_act),
        .idle_req(idle_req), .irq_pend(irq_pend), .evt_pend(evt_pend),
        .idle_ack(idle_ack), .keep_iclk(keep_iclk), .keep_fclk(keep_fclk),
        .wake_req(wake_req)
    );

    task automatic check(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic string ack_tag(logic was_ack, logic [1:0] md);
        if (was_ack) return idle_req ? "R5" : "R6";
        case (md)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R4";
            default: return "R3";
        endcase
    endfunction

    function automatic logic next_ack(logic was_ack, logic req, logic [1:0] md, logic busy);
        if (was_ack) return req;
        return req && (md == 2'b00 || (md == 2'b10 && !busy));
    endfunction

    task automatic model_reset();
        m_ack = 0; m_wake = 0; m_ki = 1; m_kf = 1; m_pi = '0; m_pe = '0;
    endtask

    task automatic step();
        logic busy, rise, n_ack;
        string t;
        @(posedge clk);
        busy  = (|irq_pend) || (|evt_pend);
        rise  = (|(irq_pend & ~m_pi)) || (|(evt_pend & ~m_pe));
        t     = ack_tag(m_ack, idle_mode);
        n_ack = next_ack(m_ack, idle_req, idle_mode, busy);
        m_wake = m_ack && idle_req && (m_wake || rise);
        m_ack = n_ack;
        m_ki  = n_ack ? clk_act[0] : 1'b1;
        m_kf  = n_ack ? clk_act[1] : 1'b1;
        m_pi  = irq_pend;
        m_pe  = evt_pend;
        #1;
        check(t,    "idle_ack",  idle_ack,  m_ack);
        check("R7", "keep_iclk", keep_iclk, m_ki);
        check("R7", "keep_fclk", keep_fclk, m_kf);
        check("R8", "wake_req",  wake_req,  m_wake);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        // R9 reset values
        check("R9", "idle_ack",  idle_ack,  1'b0);
        check("R9", "wake_req",  wake_req,  1'b0);
        check("R9", "keep_iclk", keep_iclk, 1'b1);
        check("R9", "keep_fclk", keep_fclk, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 force-idle with everything pending
        idle_mode = 2'b00; clk_act = 2'b01; irq_pend = '1; evt_pend = '1; idle_req = 1;
        step();
        check("R1", "immediate ack", idle_ack, 1'b1);
        // R8 a new line while idle: clear one, then raise it again
        irq_pend = 3'b110; step();
        irq_pend = 3'b111; step(); step();
        check("R8", "wake on new pending", wake_req, 1'b1);
        // R6 drop request
        idle_req = 0; step();
        check("R6", "ack drop", idle_ack, 1'b0);

        // R2 and R3 never grant
        irq_pend = '0; evt_pend = '0;
        idle_mode = 2'b01; idle_req = 1; repeat (4) step();
        check("R2", "no-idle", idle_ack, 1'b0);
        idle_mode = 2'b11; repeat (4) step();
        check("R3", "reserved", idle_ack, 1'b0);
        idle_req = 0; step();

        // R4 smart waits for the last event line to clear
        idle_mode = 2'b10; clk_act = 2'b10; evt_pend = 2'b10; idle_req = 1;
        repeat (3) step();
        check("R4", "wait busy", idle_ack, 1'b0);
        evt_pend = '0; step();
        check("R4", "grant when clear", idle_ack, 1'b1);
        check("R7", "functional only", keep_fclk & ~keep_iclk, 1'b1);
        // R5 changes while held; R8 top event bit rises
        idle_mode = 2'b01; evt_pend = 2'b10; step(); step();
        check("R5", "held", idle_ack, 1'b1);
        check("R8", "event wake", wake_req, 1'b1);
        idle_req = 0; step();
        evt_pend = '0; step();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 15) == 0) idle_mode = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 7) == 0)  idle_req = ~idle_req;
            if ($urandom_range(0, 5) == 0)  clk_act = 2'($urandom_range(0, 3));
            irq_pend = ($urandom_range(0, 3) == 0) ? NI'($urandom) : '0;
            evt_pend = ($urandom_range(0, 3) == 0) ? NE'($urandom) : '0;
            step();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule